// File: doc/BRIEF.md
# Digital OOK Clock and Data Recovery

This block recovers a bit clock and the data bits from an on-off-keyed power carrier. It runs entirely on the carrier clock. That clock comes from a comparator with a narrow hysteresis window, which keeps toggling even while the carrier is only partly suppressed. A second comparator with a wide window stops toggling as soon as the carrier dips. On every carrier edge its state is sampled, and the last few samples are put to a majority vote. The result is a clean envelope that is free of glitches.

A counter on the carrier clock divides it by a fixed ratio to mark the bit periods. The counter is held at zero while the envelope is low, so every carrier gap re-aligns the bit timing. The transmitter sends a one as carrier present for a whole bit period. It sends a zero as a short carrier gap at the tail of the bit period. A bit period that runs out with the envelope high yields a one. A falling envelope yields a zero, whatever the length of the gap. A long unbroken run of ones raises a one-cycle system reset request.

Top module: `ook_cdr`

## Requirements
- R1: While and right after synchronous reset, `env_o`, `bit_valid_o`, `bit_o` and `long_reset_o` are all 0, and the envelope reads as low.
- R2: `wide_i`, sampled on the carrier clock, reads 0 while the carrier is present and 1 while it is absent. `env_o` is 1 when at most one of the last three samples is 1. After two consecutive 0 samples following a gap, `env_o` rises.
- R3: A single-cycle 1 sample inside a carrier-present stretch, or a single-cycle 0 sample inside a gap, changes neither `env_o` nor the decoded bit stream.
- R4: While the envelope stays high, a one is emitted (`bit_valid_o`=1, `bit_o`=1) every DIV carrier cycles. The first one comes DIV cycles after the envelope rises.
- R5: In the cycle after `env_o` falls, a zero is emitted (`bit_valid_o`=1, `bit_o`=0). Only one zero is emitted per gap, however long the gap is.
- R6: The bit counter is held while the envelope is low and restarts when it rises. After a zero sent with a g-cycle gap, the next one strobe therefore follows the zero strobe by DIV+g-1 cycles.
- R7: For any bit sequence whose zeros use gaps of 2 to DIV-2 cycles, the decoded bits equal the sent bits, in order.
- R8: `long_reset_o` pulses for one cycle, in the cycle after the strobe of the ONES_LIMIT-th consecutive one. It pulses only once per run. Any zero restarts the run.
- R9: `bit_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock from the narrow-threshold comparator |
| rst | input | 1 | Synchronous active-high reset |
| wide_i | input | 1 | Wide-threshold comparator output (1 = not toggling / carrier absent at sample) |
| env_o | output | 1 | Deglitched envelope, 1 = carrier present |
| bit_valid_o | output | 1 | One-cycle strobe marking a decoded bit |
| bit_o | output | 1 | Decoded bit value, meaningful with `bit_valid_o` |
| long_reset_o | output | 1 | One-cycle pulse after a long uninterrupted run of ones |

## Verification
The bench builds the block with a divide ratio of 9, a three-tap vote and a ones limit of 6. The run-length reset, which would need about 600,000 bits at the default limit, is therefore reached within a few dozen bits, and both sides of its threshold are exercised. With the ratio of 9, every legal gap length from 2 to 7 cycles fits in one bit period. That makes the gap-dependent resync spacing, and an over-long gap that stretches far past a bit period, directly measurable in strobe timestamps.

// File: rtl/ook_cdr_pkg.sv
package ook_cdr_pkg;

    typedef enum logic {
        ENV_LOW  = 1'b0,
        ENV_HIGH = 1'b1
    } env_state_t;

    typedef struct packed {
        logic valid;
        logic value;
    } bit_evt_t;

    localparam int unsigned DEF_DIV        = 9;
    localparam int unsigned DEF_TAPS       = 3;
    localparam int unsigned DEF_ONES_LIMIT = 602667;

    function automatic env_state_t vote_env(input int unsigned high_cnt,
                                            input int unsigned taps);
        return (2 * high_cnt < taps) ? ENV_HIGH : ENV_LOW;
    endfunction

endpackage

// File: rtl/ook_env_detect.sv
module ook_env_detect
    import ook_cdr_pkg::*;
#(
    parameter int unsigned TAPS = DEF_TAPS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wide_i,
    output env_state_t env_o
);
    localparam int unsigned CNT_W = $clog2(TAPS + 1);

    logic [TAPS-1:0]  smp_q;
    logic [CNT_W-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '1;
        end else begin
            smp_q <= {smp_q[TAPS-2:0], wide_i};
        end
    end

    always_comb begin
        high_cnt = '0;
        for (int i = 0; i < int'(TAPS); i++) begin
            high_cnt = high_cnt + CNT_W'(smp_q[i]);
        end
    end

    assign env_o = vote_env(int'(high_cnt), TAPS);

endmodule

// File: rtl/ook_bit_timer.sv
module ook_bit_timer
    import ook_cdr_pkg::*;
#(
    parameter int unsigned DIV = DEF_DIV
) (
    input  logic       clk,
    input  logic       rst,
    input  env_state_t env_i,
    output bit_evt_t   evt_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;
    env_state_t    env_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            env_q   <= ENV_LOW;
            evt_o   <= '0;
        end else begin
            env_q <= env_i;
            evt_o <= '0;
            if (env_i == ENV_LOW) begin
                phase_q <= '0;
                if (env_q == ENV_HIGH) begin
                    evt_o <= '{valid: 1'b1, value: 1'b0};
                end
            end else if (phase_q == LAST) begin
                phase_q <= '0;
                evt_o   <= '{valid: 1'b1, value: 1'b1};
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ook_ones_watch.sv
module ook_ones_watch
    import ook_cdr_pkg::*;
#(
    parameter int unsigned ONES_LIMIT = DEF_ONES_LIMIT
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt_i,
    output logic     pulse_o
);
    localparam int unsigned RW = $clog2(ONES_LIMIT + 1);
    localparam logic [RW-1:0] FULL     = RW'(ONES_LIMIT);
    localparam logic [RW-1:0] PRE_FULL = RW'(ONES_LIMIT - 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= 1'b0;
            if (evt_i.valid) begin
                if (evt_i.value) begin
                    if (run_q == PRE_FULL) begin
                        pulse_o <= 1'b1;
                    end
                    if (run_q != FULL) begin
                        run_q <= run_q + 1'b1;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/ook_cdr.sv
module ook_cdr
    import ook_cdr_pkg::*;
#(
    parameter int unsigned DIV        = DEF_DIV,
    parameter int unsigned TAPS       = DEF_TAPS,
    parameter int unsigned ONES_LIMIT = DEF_ONES_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic wide_i,
    output logic env_o,
    output logic bit_valid_o,
    output logic bit_o,
    output logic long_reset_o
);
    env_state_t env;
    bit_evt_t   evt;

    ook_env_detect #(.TAPS(TAPS)) u_env (
        .clk   (clk),
        .rst   (rst),
        .wide_i(wide_i),
        .env_o (env)
    );

    ook_bit_timer #(.DIV(DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .env_i(env),
        .evt_o(evt)
    );

    ook_ones_watch #(.ONES_LIMIT(ONES_LIMIT)) u_ones (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .pulse_o(long_reset_o)
    );

    assign env_o       = (env == ENV_HIGH);
    assign bit_valid_o = evt.valid;
    assign bit_o       = evt.value;

endmodule

// File: rtl/ook_cdr_chk.sv
module ook_cdr_chk (
    input logic clk,
    input logic rst,
    input logic env_o,
    input logic bit_valid_o,
    input logic bit_o,
    input logic long_reset_o
);
    // R5: falling envelope yields a zero strobe in the next cycle
    p_zero_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(env_o) |=> (bit_valid_o && !bit_o));

    // R4: no one is decoded while the envelope reads low
    p_no_one_while_low_r4: assert property (@(posedge clk) disable iff (rst)
        !env_o |=> !(bit_valid_o && bit_o));

    // R9: strobes last one cycle
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |=> !bit_valid_o);

    // R8: reset request is a single-cycle pulse
    p_long_single_r8: assert property (@(posedge clk) disable iff (rst)
        long_reset_o |=> !long_reset_o);

    // R8: reset request follows a one strobe by one cycle
    p_long_after_one_r8: assert property (@(posedge clk) disable iff (rst)
        long_reset_o |-> $past(bit_valid_o && bit_o));

    // R1: outputs idle during reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!bit_valid_o && !long_reset_o));

endmodule

bind ook_cdr ook_cdr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .env_o       (env_o),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o),
    .long_reset_o(long_reset_o)
);

// File: tb/sim_ook_cdr.sv
module sim_ook_cdr;
    localparam int DIV   = 9;
    localparam int LIMIT = 6;
    localparam int NVEC  = 6;
    // {bit count, gap cycles, pattern MSB-first}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {4'd8, 4'd2, 8'hA5},
        {4'd8, 4'd3, 8'h3C},
        {4'd8, 4'd4, 8'h00},
        {4'd8, 4'd5, 8'hFF},
        {4'd6, 4'd7, 8'h16},
        {4'd8, 4'd2, 8'h81}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wide_i = 1'b1;
    logic env_o, bit_valid_o, bit_o, long_reset_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit exp_bits [0:1023];
    int sent_n = 0;
    int exp_run = 0;
    int exp_pulses = 0;

    bit rx_bits [0:1023];
    int rx_cyc [0:1023];
    int rx_n = 0;
    int rx_run = 0;
    int pulses = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ook_cdr #(.DIV(DIV), .TAPS(3), .ONES_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst(rst), .wide_i(wide_i), .env_o(env_o),
        .bit_valid_o(bit_valid_o), .bit_o(bit_o), .long_reset_o(long_reset_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst && bit_valid_o && rx_n < 1024) begin
            rx_bits[rx_n] = bit_o;
            rx_cyc[rx_n]  = cyc;
            rx_n++;
            if (bit_o) rx_run++;
            else rx_run = 0;
        end
        if (!rst && long_reset_o) begin
            pulses++;
            chk(rx_run == LIMIT, "R8 pulse position", rx_run, LIMIT);
        end
    end

    task automatic drive(input logic v);
        @(negedge clk);
        wide_i = v;
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) drive(1'b1);
    endtask

    task automatic note_bit(input bit v);
        exp_bits[sent_n] = v;
        sent_n++;
        if (v) begin
            exp_run++;
            if (exp_run == LIMIT) exp_pulses++;
        end else begin
            exp_run = 0;
        end
    endtask

    task automatic send_bit(input bit v, input int gap, input int extra);
        for (int k = 0; k < DIV; k++) drive(!v && (k >= DIV - gap));
        if (!v) hold(extra);
        note_bit(v);
    endtask

    task automatic compare_all(input string req);
        int bad = 0;
        int lim = (rx_n < sent_n) ? rx_n : sent_n;
        chk(rx_n == sent_n, req, rx_n, sent_n);
        for (int i = 0; i < lim; i++) if (rx_bits[i] != exp_bits[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        int p0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(env_o == 1'b0, "R1 env", env_o, 0);
        chk(bit_valid_o == 1'b0 && bit_o == 1'b0, "R1 strobe", bit_valid_o, 0);
        chk(long_reset_o == 1'b0, "R1 long", long_reset_o, 0);
        rst = 1'b0;
        hold(3);
        chk(env_o == 1'b0 && rx_n == 0, "R1 idle after reset", rx_n, 0);

        // R2: envelope rise needs two carrier samples
        drive(1'b0);
        drive(1'b0);
        chk(env_o == 1'b0, "R2 one sample", env_o, 0);
        drive(1'b0);
        chk(env_o == 1'b1, "R2 two samples", env_o, 1);
        for (int k = 3; k < DIV; k++) drive(1'b0);
        note_bit(1'b1);
        send_bit(1'b0, 3, 0);
        hold(4);
        compare_all("R2 first bits");

        // R7: table walk
        for (int v = 0; v < NVEC; v++) begin
            int nb  = int'(VEC[v][15:12]);
            int gp  = int'(VEC[v][11:8]);
            for (int b = nb - 1; b >= 0; b--) send_bit(VEC[v][b], gp, 0);
            send_bit(1'b0, 3, 0);
            hold(4);
            compare_all($sformatf("R7 vector %0d", v));
        end

        // R3: glitch inside a one
        base = rx_n;
        for (int k = 0; k < DIV; k++) drive(k == 4);
        note_bit(1'b1);
        send_bit(1'b0, 3, 0);
        hold(4);
        chk(rx_n == base + 2 && rx_bits[base] == 1'b1, "R3 glitch in one", rx_n - base, 2);
        // R3: carrier blip inside a gap
        base = rx_n;
        drive(1'b0);
        hold(5);
        chk(rx_n == base, "R3 blip in gap count", rx_n - base, 0);
        chk(env_o == 1'b0, "R3 blip in gap env", env_o, 0);

        // R5: over-long gap gives a single zero
        base = rx_n;
        send_bit(1'b1, 0, 0);
        send_bit(1'b0, 2, 20);
        chk(rx_n == base + 2, "R5 long gap count", rx_n - base, 2);
        chk(rx_bits[base + 1] == 1'b0, "R5 long gap value", rx_bits[base + 1], 0);

        // R6/R4: resync spacing
        base = rx_n;
        send_bit(1'b1, 0, 0);
        send_bit(1'b0, 3, 0);
        send_bit(1'b1, 0, 0);
        send_bit(1'b1, 0, 0);
        send_bit(1'b0, 3, 0);
        hold(4);
        chk(rx_cyc[base + 2] - rx_cyc[base + 1] == DIV + 2, "R6 resync spacing",
            rx_cyc[base + 2] - rx_cyc[base + 1], DIV + 2);
        chk(rx_cyc[base + 3] - rx_cyc[base + 2] == DIV, "R4 one period",
            rx_cyc[base + 3] - rx_cyc[base + 2], DIV);

        // R8: one short of the limit, then exactly the limit
        p0 = pulses;
        for (int i = 0; i < LIMIT - 1; i++) send_bit(1'b1, 0, 0);
        send_bit(1'b0, 3, 0);
        hold(4);
        chk(pulses == p0, "R8 below limit", pulses - p0, 0);
        for (int i = 0; i < LIMIT + 3; i++) send_bit(1'b1, 0, 0);
        send_bit(1'b0, 3, 0);
        hold(4);
        chk(pulses == p0 + 1, "R8 at limit once", pulses - p0, 1);

        compare_all("R7 full stream");
        chk(pulses == exp_pulses, "R8 total pulses", pulses, exp_pulses);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule